// File: doc/BRIEF.md
# I2C Register-Port Target with Map Pointer

This block is an I2C target that gives a host on a two-wire bus access to a bank of 8-bit registers. The bank itself sits outside the block. A system clock that runs much faster than SCL samples both bus lines. The block finds START and STOP conditions and compares the incoming address with a fixed six-bit prefix and one strap bit. It acknowledges the bytes it accepts, and it moves data through a simple parallel register interface: an address, write data, a one-cycle write strobe, and read data that the register file returns combinationally.

The first byte after a write address is a map byte. Its top bit turns pointer auto-increment on or off, and its low seven bits load the register pointer. A read cannot load the pointer. To read from a chosen register, the host first sends a write that holds only the map byte and ends it with STOP. It then starts a read, which serves bytes from the stored pointer. SDA is driven open-drain: the block raises an output enable when it wants the line pulled low.

Top module: `i2cRegPort`

## Requirements
- R1: After reset, `sdaOe` and `regWe` are low and the register pointer is 0x00, so a read issued before any map byte returns register 0x00.
- R2: The target answers only the address byte `{1,0,0,1,1,1,addrStrap,rw}`, sent MSB first, where rw=0 means write and rw=1 means read. It acknowledges that byte by pulling SDA low during the ninth SCL pulse.
- R3: In a write, the first byte after the address is the map byte. Bit 7 is the auto-increment enable and bits 6:0 are the pointer. The byte is acknowledged, and the pointer it loads survives a STOP and is used by a later read.
- R4: Each further write byte is received MSB first. It produces exactly one single-cycle `regWe` pulse with `regAddr` equal to the pointer and `regWdata` equal to the byte, and it is acknowledged.
- R5: With auto-increment set, the pointer advances by one after each written byte and after each read byte that the host acknowledges.
- R6: With auto-increment clear, the pointer never changes, so every write byte and every read byte targets the same register.
- R7: In a read, the target sends the byte at the pointer MSB first, starting right after the address ACK. It changes SDA only while SCL is low.
- R8: A host NACK after a read byte makes the target release SDA and stay idle until the next START. The pointer does not advance for the NACKed byte.
- R9: When auto-increment is set, the pointer wraps from 0x7F to 0x00.
- R10: A repeated START in the middle of a transfer returns the target to address matching. A write that loads the map and is followed by a repeated-START read reads from the new pointer.
- R11: On an address mismatch the target does not acknowledge, issues no write strobe, and keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| addrStrap | input | 1 | Strap bit that completes the device address |
| sdaOe | output | 1 | 1 = pull SDA low, 0 = release |
| regAddr | output | 7 | Register pointer presented to the register file |
| regWdata | output | 8 | Byte to write |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Register contents at `regAddr`, returned combinationally |

## Verification
The bench writes three bytes with auto-increment set and two bytes with it clear. This separates a pointer that advances from one that holds. It then reads the same registers back, after an aborted write or after a repeated START, which shows that the pointer survives STOP and that a repeated START returns to address matching. Writing across 0x7F shows the wrap. A NACKed final byte followed by a second read shows that the pointer did not advance for the NACKed byte. Addressing the target with the wrong strap bit, and then with the right one, shows that the strap takes part in the address match and that a non-matching target stays silent.

// File: rtl/i2cRegPortPkg.sv
package i2cRegPortPkg;

  typedef enum logic [2:0] {
    ST_IDLE,     // released, waiting for START
    ST_RX,       // shifting in a byte
    ST_ACKWAIT,  // byte taken, waiting for SCL low to drive ACK
    ST_ACKDRV,   // holding ACK through the ninth pulse
    ST_TX,       // shifting out a byte
    ST_TXACK,    // released, sampling host ACK/NACK
    ST_TXLOAD    // host acked, load next byte on SCL low
  } portState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_MAP,
    K_DATA
  } rxKind_t;

  typedef struct packed {
    logic shiftRx;
    logic capMap;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
    logic incPtr;
    logic drvAck;
    logic txActive;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cPortDp.sv
module i2cPortDp
  import i2cRegPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-3:0] ADDR_HI = 6'b100111,
  localparam int PTR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] regRdata,
  output logic              sclRise,
  output logic              sclFall,
  output logic              busStart,
  output logic              busStop,
  output logic              sdaBit,
  output logic              rwBit,
  output logic              addrHit,
  output logic              sclLvl,
  output logic              autoIncLvl,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD;
  logic [DATA_W-1:0] rxSh, txSh, rxNext;
  logic [PTR_W-1:0] ptr;
  logic autoInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclSync[SYNC_STAGES-1];
      sdaD    <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclLvl   = sclSync[SYNC_STAGES-1];
  assign sdaBit   = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclLvl & ~sclD;
  assign sclFall  = ~sclLvl & sclD;
  assign busStart = sclLvl & sclD & sdaD & ~sdaBit;
  assign busStop  = sclLvl & sclD & ~sdaD & sdaBit;

  assign rxNext  = {rxSh[DATA_W-2:0], sdaBit};
  assign rwBit   = rxNext[0];
  assign addrHit = (rxNext[DATA_W-1:1] == {ADDR_HI, addrStrap});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      txSh    <= '1;
      ptr     <= '0;
      autoInc <= 1'b0;
    end else begin
      if (stb.shiftRx) rxSh <= rxNext;
      if (stb.loadTx) txSh <= regRdata;
      else if (stb.shiftTx) txSh <= {txSh[DATA_W-2:0], 1'b1};
      if (stb.capMap) begin
        autoInc <= rxNext[DATA_W-1];
        ptr     <= rxNext[PTR_W-1:0];
      end else if ((stb.wrReg | stb.incPtr) & autoInc) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign sdaOe      = stb.drvAck | (stb.txActive & ~txSh[DATA_W-1]);
  assign regAddr    = ptr;
  assign regWdata   = rxNext;
  assign autoIncLvl = autoInc;

endmodule

// File: rtl/i2cPortCtrl.sv
module i2cPortCtrl
  import i2cRegPortPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       busStart,
  input  logic       busStop,
  input  logic       sdaBit,
  input  logic       rwBit,
  input  logic       addrHit,
  output ctlStrobe_t stb,
  output logic       stIdle
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

  portState_t state, nState;
  rxKind_t kind, nKind;
  logic rwRd, nRwRd;
  logic [CNT_W-1:0] cnt, nCnt;

  always_comb begin
    nState = state;
    nKind  = kind;
    nRwRd  = rwRd;
    nCnt   = cnt;
    stb    = '0;
    stb.drvAck   = (state == ST_ACKDRV);
    stb.txActive = (state == ST_TX);
    if (busStart) begin
      nState = ST_RX;
      nKind  = K_ADDR;
      nCnt   = '0;
    end else if (busStop) begin
      nState = ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: if (sclRise) begin
          stb.shiftRx = 1'b1;
          nCnt = cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            nCnt = '0;
            nState = ST_ACKWAIT;
            unique case (kind)
              K_ADDR: begin
                nRwRd = rwBit;
                if (!addrHit) nState = ST_IDLE;
              end
              K_MAP:   stb.capMap = 1'b1;
              default: stb.wrReg = 1'b1;
            endcase
          end
        end
        ST_ACKWAIT: if (sclFall) nState = ST_ACKDRV;
        ST_ACKDRV: if (sclFall) begin
          if (kind == K_ADDR && rwRd) begin
            stb.loadTx = 1'b1;
            nCnt = '0;
            nState = ST_TX;
          end else begin
            nState = ST_RX;
            nKind = (kind == K_ADDR) ? K_MAP : K_DATA;
          end
        end
        ST_TX: begin
          if (sclRise) nCnt = cnt + 1'b1;
          else if (sclFall) begin
            if (cnt == ALL_BITS) nState = ST_TXACK;
            else stb.shiftTx = 1'b1;
          end
        end
        ST_TXACK: if (sclRise) begin
          if (!sdaBit) begin
            stb.incPtr = 1'b1;
            nState = ST_TXLOAD;
          end else begin
            nState = ST_IDLE;
          end
        end
        ST_TXLOAD: if (sclFall) begin
          stb.loadTx = 1'b1;
          nCnt = '0;
          nState = ST_TX;
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= K_ADDR;
      rwRd  <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= nState;
      kind  <= nKind;
      rwRd  <= nRwRd;
      cnt   <= nCnt;
    end
  end

  assign stIdle = (state == ST_IDLE);

endmodule

// File: rtl/i2cRegPort.sv
module i2cRegPort
  import i2cRegPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-3:0] ADDR_HI = 6'b100111,
  localparam int PTR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  ctlStrobe_t stb;
  logic sclRise, sclFall, busStart, busStop, sdaBit, rwBit, addrHit;
  logic sclLvl, autoIncLvl, stIdle;

  i2cPortDp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .stb(stb), .regRdata(regRdata), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop), .sdaBit(sdaBit), .rwBit(rwBit),
    .addrHit(addrHit), .sclLvl(sclLvl), .autoIncLvl(autoIncLvl), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata)
  );

  i2cPortCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop), .sdaBit(sdaBit), .rwBit(rwBit),
    .addrHit(addrHit), .stb(stb), .stIdle(stIdle)
  );

  assign regWe = stb.wrReg;

endmodule

// File: rtl/i2cRegPortChk.sv
module i2cRegPortChk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclLvl,
  input logic             sdaOe,
  input logic             regWe,
  input logic             autoIncLvl,
  input logic             stIdle,
  input logic [PTR_W-1:0] regAddr
);

  // R4
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R7
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    stIdle |-> !sdaOe);

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stIdle |-> !regWe);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !autoIncLvl) |=> regAddr == $past(regAddr));

  // R5 R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && autoIncLvl) |=> regAddr == PTR_W'($past(regAddr) + 1'b1));

endmodule

bind i2cRegPort i2cRegPortChk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaOe(sdaOe), .regWe(regWe),
  .autoIncLvl(autoIncLvl), .stIdle(stIdle), .regAddr(regAddr)
);

// File: tb/sim_i2cRegPort.sv
module sim_i2cRegPort;

  localparam int Q = 8;
  localparam logic [7:0] WR0 = 8'h9C, RD0 = 8'h9D, WR1 = 8'h9E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1, sdaHost = 1'b1, addrStrap = 1'b0;
  logic sdaOe, regWe;
  logic [6:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] regs [128];
  logic [7:0] expv [128];
  wire sdaLine = sdaHost & ~sdaOe;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  i2cRegPort u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine), .addrStrap(addrStrap),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata)
  );

  assign regRdata = regs[regAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'(i * 7 + 3);
    end else if (regWe) begin
      regs[regAddr] <= regWdata;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] want, input string tag);
    nChk++;
    if (act !== want) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, want);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaHost = 1'b1; tick(Q); sclHost = 1'b1; tick(Q);
    sdaHost = 1'b0; tick(Q); sclHost = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaHost = 1'b0; tick(Q); sclHost = 1'b1; tick(Q); sdaHost = 1'b1; tick(Q);
  endtask

  task automatic putBit(input logic b);
    sdaHost = b; tick(Q); sclHost = 1'b1; tick(2 * Q); sclHost = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    sdaHost = 1'b1; tick(Q); sclHost = 1'b1; tick(Q);
    b = sdaLine; tick(Q); sclHost = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(a);
    acked = ~a;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) getBit(b[i]);
    putBit(nack);
  endtask

  task automatic tReset();
    logic ak; logic [7:0] d;
    chk({7'd0, sdaOe}, 8'd0, "R1 sdaOe after reset");
    chk({7'd0, regWe}, 8'd0, "R1 regWe after reset");
    busStart(); sendByte(RD0, ak);
    chk({7'd0, ak}, 8'd1, "R2 read address ack");
    recvByte(d, 1'b1); busStop();
    chk(d, expv[0], "R1 pointer 0 after reset");
  endtask

  task automatic tWriteInc();
    logic ak;
    busStart(); sendByte(WR0, ak);
    chk({7'd0, ak}, 8'd1, "R2 write address ack");
    sendByte(8'h90, ak);
    chk({7'd0, ak}, 8'd1, "R3 map byte ack");
    sendByte(8'hA5, ak); sendByte(8'h3C, ak); sendByte(8'hF0, ak);
    chk({7'd0, ak}, 8'd1, "R4 data byte ack");
    busStop();
    expv[8'h10] = 8'hA5; expv[8'h11] = 8'h3C; expv[8'h12] = 8'hF0;
    for (int i = 16; i < 19; i++) chk(regs[i], expv[i], "R5 R4 autoinc write");
  endtask

  task automatic tWriteHold();
    logic ak;
    busStart(); sendByte(WR0, ak); sendByte(8'h20, ak);
    sendByte(8'h11, ak); sendByte(8'h22, ak); busStop();
    expv[8'h20] = 8'h22;
    chk(regs[8'h20], expv[8'h20], "R6 same register rewritten");
    chk(regs[8'h21], expv[8'h21], "R6 neighbour untouched");
  endtask

  task automatic tAbortRead();
    logic ak; logic [7:0] d;
    busStart(); sendByte(WR0, ak); sendByte(8'h90, ak); busStop();
    busStart(); sendByte(RD0, ak);
    recvByte(d, 1'b0); chk(d, expv[8'h10], "R3 R7 first read byte");
    recvByte(d, 1'b0); chk(d, expv[8'h11], "R5 second read byte");
    recvByte(d, 1'b1); chk(d, expv[8'h12], "R5 third read byte");
    tick(4);
    chk({7'd0, sdaOe}, 8'd0, "R8 released after NACK");
    busStop();
    busStart(); sendByte(RD0, ak); recvByte(d, 1'b1); busStop();
    chk(d, expv[8'h12], "R8 pointer kept after NACK");
  endtask

  task automatic tWrap();
    logic ak;
    busStart(); sendByte(WR0, ak); sendByte(8'hFF, ak);
    sendByte(8'h5A, ak); sendByte(8'h6B, ak); busStop();
    expv[8'h7F] = 8'h5A; expv[0] = 8'h6B;
    chk(regs[8'h7F], expv[8'h7F], "R9 last register");
    chk(regs[0], expv[0], "R9 wrapped to register 0");
  endtask

  task automatic tRepStart();
    logic ak; logic [7:0] d;
    busStart(); sendByte(WR0, ak); sendByte(8'h12, ak);
    busStart(); sendByte(RD0, ak);
    chk({7'd0, ak}, 8'd1, "R10 address ack after repeated start");
    recvByte(d, 1'b0); chk(d, expv[8'h12], "R10 read from new pointer");
    recvByte(d, 1'b1); chk(d, expv[8'h12], "R6 read pointer held");
    busStop();
  endtask

  task automatic tMismatch();
    logic ak;
    busStart(); sendByte(WR1, ak);
    chk({7'd0, ak}, 8'd0, "R11 no ack on mismatch");
    sendByte(8'h05, ak);
    chk({7'd0, ak}, 8'd0, "R11 bus ignored");
    sendByte(8'h77, ak); busStop();
    chk(regs[5], expv[5], "R11 no write on mismatch");
    addrStrap = 1'b1; tick(Q);
    busStart(); sendByte(WR1, ak);
    chk({7'd0, ak}, 8'd1, "R2 strap selects address");
    sendByte(8'h05, ak); sendByte(8'h77, ak); busStop();
    expv[5] = 8'h77;
    chk(regs[5], expv[5], "R4 write with strap set");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) expv[i] = 8'(i * 7 + 3);
    tick(5);
    rstN = 1'b1;
    tick(5);
    tReset();
    tWriteInc();
    tWriteHold();
    tAbortRead();
    tWrap();
    tRepStart();
    tMismatch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule